// File: doc/BRIEF.md
# Dual-Mode Lookup / Shift-Delay Logic Cell

This cell is one configurable logic element fed by three signals from a routing fabric. A static mode pin selects one of two functions. In lookup mode the three inputs form an index into an 8-bit truth-table word, and the selected bit is driven combinationally onto the first output. With that the cell can realise any Boolean function of three variables, such as AND, OR, XOR, their complements, or an inverter.

In delay mode the three inputs take new roles. Input 0 carries data, input 1 acts as a shift clock and input 2 is an active-low clear. The data shifts down an 8-stage flop chain, and each of the two outputs taps that chain at its own programmed depth. The second output can be inverted. The shift clock is a plain data signal. It is synchronised into the free-running system clock, and each detected rising edge advances the chain by one stage. Configuration pins are static and stand in for one-time-programmed bits.

All interfaces are plain level pins. There is no data stream here, so there is no valid/ready handshake and no back-pressure. A new shift is accepted on every detected edge of input 1.

Top module: `lut_pipe_cell`

## Requirements
- R1: With `mode_dly`=0, `out0` equals `truth[{in2,in1,in0}]` combinationally, so `in2` is the most significant index bit.
- R2: With `mode_dly`=0, `out1` is held low.
- R3: With `mode_dly`=1 and `in2` high, every rising edge of `in1` shifts `in0` into stage 1. The edge takes effect within 4 system clocks. `out0` then shows the value sampled `tap0_sel`+1 edges earlier.
- R4: `out1` taps the chain at depth `tap1_sel`+1, independently of `tap0_sel`.
- R5: With `out1_inv`=1 and `in2` high, `out1` is the complement of the selected stage. `out0` is never inverted.
- R6: With `mode_dly`=1 and `in2` low, `out0` and `out1` are both low at once, including when `out1_inv`=1.
- R7: A low on `in2` clears all 8 stages. After `in2` returns high, every tap reads 0 (so an inverted `out1` reads 1) until new data shifts in.
- R8: A falling edge of `in1`, a steady level on `in1`, or a change of `in0` with no `in1` rising edge leaves the chain unchanged.
- R9: A low on the system reset `rst_n` clears the chain and the edge detector.
- R10: If `in2` is low while an `in1` rising edge is being taken, the clear wins and no data is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| mode_dly | input | 1 | 0 = lookup mode, 1 = delay mode (static) |
| truth | input | 8 | Truth-table word, bit index {in2,in1,in0} |
| tap0_sel | input | 3 | Depth of out0 minus one |
| tap1_sel | input | 3 | Depth of out1 minus one |
| out1_inv | input | 1 | 1 = invert out1 |
| in0 | input | 1 | Fabric input 0 / shift data |
| in1 | input | 1 | Fabric input 1 / shift clock |
| in2 | input | 1 | Fabric input 2 / active-low clear |
| out0 | output | 1 | Lookup result or first tap |
| out1 | output | 1 | Second tap, optionally inverted |

## Verification
The clear and the shift can fall in the same cycle. This matters because `in2` drops the chain asynchronously while a synchronised `in1` edge is still travelling through the detector. The bench raises `in1` and, two system clocks later, pulls `in2` low while that edge is still in flight. It releases the clear only after the edge has fully passed. The result is judged at the ports: after release, every tap must read zero. A second overlap is two taps reading the same stage, one true and one inverted. The bench checks that case, and so does a checker property that requires `out1` to equal `out0` XOR `out1_inv`.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int LUT_IN   = 3;
  localparam int LUT_SIZE = 1 << LUT_IN;
  localparam int DEPTH    = 8;
  localparam int TAP_W    = $clog2(DEPTH);
  localparam int SYNC_N   = 2;
  localparam int N_TAPS   = 2;
endpackage

// File: rtl/lpc_lut.sv
module lpc_lut #(
  parameter int NIN = lpc_pkg::LUT_IN
) (
  input  logic [(1<<NIN)-1:0] table_bits,
  input  logic [NIN-1:0]      sel,
  output logic                q
);
  assign q = table_bits[sel];
endmodule

// File: rtl/lpc_edge.sv
module lpc_edge #(
  parameter int SYNC = lpc_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic dclk,
  output logic dsync,
  output logic rise
);
  logic [SYNC-1:0] c_sr;
  logic [SYNC-1:0] d_sr;
  logic            c_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sr   <= '0;
      d_sr   <= '0;
      c_prev <= 1'b0;
    end else begin
      c_sr   <= {c_sr[SYNC-2:0], dclk};
      d_sr   <= {d_sr[SYNC-2:0], din};
      c_prev <= c_sr[SYNC-1];
    end
  end

  assign rise  = c_sr[SYNC-1] & ~c_prev;
  assign dsync = d_sr[SYNC-1];
endmodule

// File: rtl/lpc_chain.sv
module lpc_chain #(
  parameter int N = lpc_pkg::DEPTH
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         shift,
  input  logic         d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)     q <= '0;
    else if (shift) q <= {q[N-2:0], d};
  end
endmodule

// File: rtl/lut_pipe_cell.sv
module lut_pipe_cell
  import lpc_pkg::*;
#(
  parameter int TW = TAP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_dly,
  input  logic [LUT_SIZE-1:0] truth,
  input  logic [TW-1:0]       tap0_sel,
  input  logic [TW-1:0]       tap1_sel,
  input  logic                out1_inv,
  input  logic                in0,
  input  logic                in1,
  input  logic                in2,
  output logic                out0,
  output logic                out1
);
  logic             lut_q;
  logic             d_s, rise;
  logic             chain_clr_n;
  logic             run;
  logic [DEPTH-1:0] stages;
  logic [N_TAPS-1:0] tap_q;
  logic [TW-1:0]    tap_sel [N_TAPS];

  lpc_lut #(.NIN(LUT_IN)) u_lut (
    .table_bits(truth), .sel({in2, in1, in0}), .q(lut_q)
  );

  lpc_edge #(.SYNC(SYNC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(in0), .dclk(in1), .dsync(d_s), .rise(rise)
  );

  assign run         = rst_n & mode_dly & in2;
  assign chain_clr_n = run;

  lpc_chain #(.N(DEPTH)) u_chain (
    .clk(clk), .clr_n(chain_clr_n), .shift(rise), .d(d_s), .q(stages)
  );

  assign tap_sel[0] = tap0_sel;
  assign tap_sel[1] = tap1_sel;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign tap_q[t] = stages[tap_sel[t]];
  end

  assign out0 = mode_dly ? (run & tap_q[0]) : lut_q;
  assign out1 = run & (tap_q[1] ^ out1_inv);
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_dly,
  input logic [7:0] truth,
  input logic [2:0] tap0_sel,
  input logic [2:0] tap1_sel,
  input logic       out1_inv,
  input logic       in0,
  input logic       in1,
  input logic       in2,
  input logic       out0,
  input logic       out1
);
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  a_r1_lut_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_dly |-> out0 == truth[{in2, in1, in0}]);

  a_r2_out1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_dly |-> !out1);

  a_r6_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dly && !in2) |-> (!out0 && !out1));

  a_r5_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dly && in2 && tap0_sel == tap1_sel) |-> (out1 == (out0 ^ out1_inv)));

  a_r8_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd7 && mode_dly && in2 && $past(in2) && !in1 && !$past(in1)
     && !$past(in1, 2) && !$past(in1, 3) && !$past(in1, 4)
     && $stable(tap0_sel) && $stable(mode_dly)) |-> $stable(out0));
endmodule

bind lut_pipe_cell lpc_checker u_chk (.*);

// File: tb/tb_lut_pipe_cell.sv
`timescale 1ns/1ps
module tb_lut_pipe_cell;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode_dly = 0;
  logic [7:0] truth = 0;
  logic [2:0] tap0_sel = 0, tap1_sel = 0;
  logic       out1_inv = 0;
  logic       in0 = 0, in1 = 0, in2 = 1;
  logic       out0, out1;

  int n_run = 0, n_fail = 0;
  logic [7:0] hist = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lut_pipe_cell dut (.*);

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic d);
    in0 = d;
    @(negedge clk); in1 = 1;
    repeat (4) @(negedge clk);
    in1 = 0;
    repeat (4) @(negedge clk);
    hist = {hist[6:0], d};
  endtask

  task automatic t_reset();
    mode_dly = 1; in2 = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset out0", out0, 0);
    chk("R9 reset out1", out1, 0);
    rst_n = 1; @(negedge clk);
    hist = 0;
  endtask

  task automatic t_lut();
    logic [7:0] tabs [5] = '{8'h80, 8'h96, 8'h01, 8'h55, 8'hA6};
    mode_dly = 0;
    foreach (tabs[k]) begin
      truth = tabs[k];
      for (int i = 0; i < 8; i++) begin
        {in2, in1, in0} = i[2:0];
        #1;
        chk("R1 lut", out0, tabs[k][i]);
        chk("R2 out1 low", out1, 0);
      end
    end
    in0 = 0; in1 = 0; in2 = 1;
    @(negedge clk);
  endtask

  task automatic t_taps();
    logic [7:0] pat = 8'b1011_0010;
    mode_dly = 1; in2 = 1; out1_inv = 0;
    for (int i = 0; i < 8; i++) shift_bit(pat[i]);
    for (int a = 0; a < 8; a++) begin
      tap0_sel = a[2:0]; tap1_sel = 3'(7 - a); #1;
      chk("R3 tap0 depth", out0, hist[a]);
      chk("R4 tap1 depth", out1, hist[7-a]);
    end
  endtask

  task automatic t_inv();
    out1_inv = 1;
    for (int a = 0; a < 8; a++) begin
      tap0_sel = a[2:0]; tap1_sel = a[2:0]; #1;
      chk("R5 inverted out1", out1, ~hist[a]);
      chk("R5 out0 true", out0, hist[a]);
    end
  endtask

  task automatic t_clear();
    tap0_sel = 0; tap1_sel = 0; out1_inv = 1;
    shift_bit(1);
    in2 = 0; #1;
    chk("R6 out0 low", out0, 0);
    chk("R6 out1 low inv", out1, 0);
    @(negedge clk); in2 = 1; hist = 0; #1;
    for (int a = 0; a < 8; a++) begin
      tap0_sel = a[2:0]; tap1_sel = a[2:0]; #1;
      chk("R7 cleared tap0", out0, 0);
      chk("R7 cleared inv tap1", out1, 1);
    end
    out1_inv = 0;
  endtask

  task automatic t_no_edge();
    shift_bit(1); shift_bit(0); shift_bit(1);
    in1 = 1; repeat (4) @(negedge clk);
    hist = {hist[6:0], 1'b1};
    in0 = 0; repeat (4) @(negedge clk);
    in1 = 0; in0 = 1; repeat (6) @(negedge clk);
    in0 = 0; repeat (6) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      tap0_sel = a[2:0]; #1;
      chk("R8 no shift without rise", out0, hist[a]);
    end
  endtask

  task automatic t_collide();
    in0 = 1;
    @(negedge clk); in1 = 1;
    repeat (2) @(negedge clk);
    in2 = 0;
    repeat (4) @(negedge clk);
    in2 = 1; in1 = 0;
    repeat (4) @(negedge clk);
    hist = 0;
    for (int a = 0; a < 8; a++) begin
      tap0_sel = a[2:0]; tap1_sel = a[2:0]; #1;
      chk("R10 clear wins tap0", out0, 0);
      chk("R10 clear wins tap1", out1, 0);
    end
  endtask

  task automatic t_sysreset();
    shift_bit(1);
    tap0_sel = 0; #1;
    chk("R3 single shift", out0, 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R9 chain cleared", out0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog: got hang expected completion");
          $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
          $finish;
        end
      end
    join_none
    @(negedge clk);
    t_reset();
    t_lut();
    t_taps();
    t_inv();
    t_clear();
    t_no_edge();
    t_collide();
    t_sysreset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule